// File: doc/BRIEF.md
# Life Strip Row Engine

This block updates one vertical strip of a Game of Life grid. The strip is `W` cells wide and `ROWS` rows tall, and it holds one bit per cell in a local two-port memory. A wide grid is built from many copies of the strip placed side by side. All copies receive the same one-cycle `sync_i` pulse and the same row number, so they compute that row together and in lockstep. Each strip publishes the three cells of its leftmost and rightmost columns for the row being computed, covering the row above, the row itself and the row below. Its two neighbours take these cells in through their `nbr_l_i` / `nbr_r_i` ports.

The memory is organised as one `W`-bit word per row. Bit `j` of a word is the cell at position `j` inside the strip, and bit 0 is the leftmost cell. When a row starts, the engine reads the row itself and the row below from memory. It takes the row above from a register buffer, because memory already holds that row's new generation. It then exchanges edge cells with its neighbours and walks the `W` cell positions one per cycle with a sliding 3x3 window. The results are collected in a register and written back as a single word. The frame controller must request rows in increasing order, starting at row 0 in each generation.

A second, read-only memory port lets a display scan the strip. A load port lets the controller seed rows while the engine is idle.

Top module: `life_strip`

## Requirements
- R1: After reset, `busy_o` is low and both `edge_l_o` and `edge_r_o` are zero.
- R2: Each new cell follows the life rule. A live cell with 2 or 3 live neighbours stays live, a dead cell with exactly 3 live neighbours becomes live, and every other cell becomes dead.
- R3: The row above is the pre-update content of the row handled by the previous `sync_i` operation. For row 0 the row above reads as dead.
- R4: For row `ROWS-1`, the row below reads as dead.
- R5: The left column of the window at position 0 comes from `nbr_l_i`, and the right column at position `W-1` comes from `nbr_r_i`. In both, bit 2 is the row above, bit 1 is the row itself and bit 0 is the row below.
- R6: Once a row completes, `edge_l_o` holds the pre-update cells at position 0 and `edge_r_o` holds those at position `W-1`, with the same bit order as R5. Both stay constant until the next accepted `sync_i`.
- R7: `sync_i` seen while idle makes `busy_o` high from the next cycle for exactly `W+5` cycles. The new row word is in memory when `busy_o` falls.
- R8: `ld_i` writes `ld_data_i` to row `ld_row_i` when the engine is idle. While `busy_o` is high, `ld_i` has no effect.
- R9: `sync_i` is ignored while `busy_o` is high.
- R10: `disp_data_o` returns the word of row `disp_row_i` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | One-cycle start pulse for a row |
| row_i | input | RW | Row to compute, sampled with `sync_i` |
| busy_o | output | 1 | High while a row is being computed |
| nbr_l_i | input | 3 | Edge cells exposed by the left neighbour (up, mid, low) |
| nbr_r_i | input | 3 | Edge cells exposed by the right neighbour (up, mid, low) |
| edge_l_o | output | 3 | This strip's leftmost cells (up, mid, low) |
| edge_r_o | output | 3 | This strip's rightmost cells (up, mid, low) |
| ld_i | input | 1 | Seed write enable |
| ld_row_i | input | RW | Seed write row |
| ld_data_i | input | W | Seed write word |
| disp_row_i | input | RW | Display read row |
| disp_data_o | output | W | Display read word, one cycle latency |

## Verification
The sync pulse is sampled on one clock edge, and `busy_o` rises on that same edge. The bench then counts the cycles in which `busy_o` is high, sampling each one at the falling clock edge, and expects exactly `W+5`. Only after `busy_o` falls does the driver queue the expected word and edges. The monitor then presents the row address on the display port and compares `disp_data_o` one full cycle later. The edge outputs are compared in that same cycle, since they are held until the next row starts. The load and sync pulses injected during a busy row are checked afterwards through the busy length, through the display port and through the word of the next row computed.

// File: rtl/life_pkg.sv
package life_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_MID,
    ST_RD_LOW,
    ST_CAP,
    ST_XCHG,
    ST_CELL,
    ST_WR
  } strip_st_e;
endpackage

// File: rtl/life_mem.sv
module life_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 480,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic          a_we_i,
  input  logic [W-1:0]  a_wdata_i,
  output logic [W-1:0]  a_rdata_o,
  input  logic [AW-1:0] b_addr_i,
  output logic [W-1:0]  b_rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    a_rdata_o <= mem_q[a_addr_i];
    b_rdata_o <= mem_q[b_addr_i];
  end
endmodule

// File: rtl/life_rule.sv
module life_rule (
  input  logic [2:0] up_i,
  input  logic [2:0] mid_i,
  input  logic [2:0] low_i,
  output logic       nxt_o
);
  logic [3:0] cnt;
  always_comb begin
    cnt = '0;
    for (int i = 0; i < 3; i++) begin
      cnt = cnt + 4'(up_i[i]) + 4'(low_i[i]);
    end
    cnt = cnt + 4'(mid_i[0]) + 4'(mid_i[2]);
    nxt_o = (cnt == 4'd3) || (mid_i[1] && cnt == 4'd2);
  end
endmodule

// File: rtl/life_strip.sv
module life_strip
  import life_pkg::*;
#(
  parameter int W    = 8,
  parameter int ROWS = 480,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [RW-1:0] row_i,
  output logic          busy_o,
  input  logic [2:0]    nbr_l_i,
  input  logic [2:0]    nbr_r_i,
  output logic [2:0]    edge_l_o,
  output logic [2:0]    edge_r_o,
  input  logic          ld_i,
  input  logic [RW-1:0] ld_row_i,
  input  logic [W-1:0]  ld_data_i,
  input  logic [RW-1:0] disp_row_i,
  output logic [W-1:0]  disp_data_o
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_COL = CW'(W - 1);

  strip_st_e     state_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [W-1:0]  mid_q, prev_q, res_q;
  logic [W+1:0]  up_x, mid_x, low_x;  // bit 0 = left nbr, bit W+1 = right nbr

  logic [RW-1:0] a_addr;
  logic          a_we;
  logic [W-1:0]  a_wdata, a_rdata;
  logic [W-1:0]  up_w, low_w;
  logic          nxt;

  assign busy_o = (state_q != ST_IDLE);
  assign up_w   = (row_q == '0) ? '0 : prev_q;
  assign low_w  = (row_q == LAST_ROW) ? '0 : a_rdata;

  always_comb begin
    a_addr  = ld_row_i;
    a_we    = 1'b0;
    a_wdata = ld_data_i;
    unique case (state_q)
      ST_IDLE:   a_we = ld_i;
      ST_RD_MID: a_addr = row_q;
      ST_RD_LOW: a_addr = (row_q == LAST_ROW) ? row_q : row_q + RW'(1);
      ST_WR: begin
        a_addr  = row_q;
        a_we    = 1'b1;
        a_wdata = res_q;
      end
      default: ;
    endcase
  end

  life_mem #(.W(W), .DEPTH(ROWS)) u_mem (
    .clk_i     (clk_i),
    .a_addr_i  (a_addr),
    .a_we_i    (a_we),
    .a_wdata_i (a_wdata),
    .a_rdata_o (a_rdata),
    .b_addr_i  (disp_row_i),
    .b_rdata_o (disp_data_o)
  );

  life_rule u_rule (
    .up_i  (up_x[2:0]),
    .mid_i (mid_x[2:0]),
    .low_i (low_x[2:0]),
    .nxt_o (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      mid_q    <= '0;
      prev_q   <= '0;
      res_q    <= '0;
      up_x     <= '0;
      mid_x    <= '0;
      low_x    <= '0;
      edge_l_o <= '0;
      edge_r_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sync_i) begin
          row_q   <= row_i;
          col_q   <= '0;
          state_q <= ST_RD_MID;
        end
        ST_RD_MID: state_q <= ST_RD_LOW;
        ST_RD_LOW: begin
          mid_q   <= a_rdata;
          state_q <= ST_CAP;
        end
        ST_CAP: begin
          up_x     <= {1'b0, up_w, 1'b0};
          mid_x    <= {1'b0, mid_q, 1'b0};
          low_x    <= {1'b0, low_w, 1'b0};
          edge_l_o <= {up_w[0], mid_q[0], low_w[0]};
          edge_r_o <= {up_w[W-1], mid_q[W-1], low_w[W-1]};
          state_q  <= ST_XCHG;
        end
        ST_XCHG: begin
          // neighbours registered their edges in ST_CAP, valid now
          up_x[0]    <= nbr_l_i[2];
          mid_x[0]   <= nbr_l_i[1];
          low_x[0]   <= nbr_l_i[0];
          up_x[W+1]  <= nbr_r_i[2];
          mid_x[W+1] <= nbr_r_i[1];
          low_x[W+1] <= nbr_r_i[0];
          state_q    <= ST_CELL;
        end
        ST_CELL: begin
          res_q <= {nxt, res_q[W-1:1]};
          up_x  <= up_x >> 1;
          mid_x <= mid_x >> 1;
          low_x <= low_x >> 1;
          col_q <= col_q + CW'(1);
          if (col_q == LAST_COL) state_q <= ST_WR;
        end
        ST_WR: begin
          prev_q  <= mid_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: accepted sync starts the row next cycle
  p_sync_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && sync_i) |=> (busy_o && state_q == ST_RD_MID));

  // R7: write-back cycle returns to idle
  p_wr_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR) |=> !busy_o);

  // R8: no seed write lands during a row
  p_ld_blocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_WR) |-> !a_we);

  // R9: sync during a row does not restart it
  p_sync_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CELL && sync_i) |=> (state_q == ST_CELL || state_q == ST_WR));

  // R6: exposed edges hold through the cell walk
  p_edge_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CELL) |=> ($stable(edge_l_o) && $stable(edge_r_o)));

  // R3: row 0 sees a dead row above
  p_top_dead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XCHG && row_q == '0) |-> (up_x[W:1] == '0));

  // R4: last row sees a dead row below
  p_bottom_dead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XCHG && row_q == LAST_ROW) |-> (low_x[W:1] == '0));
endmodule

// File: tb/sim_life_strip.sv
`timescale 1ns/1ps
module sim_life_strip;
  localparam int W    = 8;
  localparam int ROWS = 480;
  localparam int RW   = $clog2(ROWS);

  typedef struct {
    logic [RW-1:0] row;
    logic [W-1:0]  word;
    logic [2:0]    el;
    logic [2:0]    er;
    bit            chk_e;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync = 1'b0;
  logic [RW-1:0] row = '0;
  logic          busy;
  logic [2:0]    nbr_l = '0, nbr_r = '0;
  logic [2:0]    edge_l, edge_r;
  logic          ld = 1'b0;
  logic [RW-1:0] ld_row = '0;
  logic [W-1:0]  ld_data = '0;
  logic [RW-1:0] disp_row = '0;
  logic [W-1:0]  disp_data;

  int total = 0, bad = 0;
  bit finished = 0;
  item_t exp_q[$];
  logic [W-1:0] g [ROWS];
  logic [W-1:0] last_mid = '0;

  always #2.5 clk = ~clk;

  life_strip #(.W(W), .ROWS(ROWS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .row_i(row), .busy_o(busy),
    .nbr_l_i(nbr_l), .nbr_r_i(nbr_r), .edge_l_o(edge_l), .edge_r_o(edge_r),
    .ld_i(ld), .ld_row_i(ld_row), .ld_data_i(ld_data),
    .disp_row_i(disp_row), .disp_data_o(disp_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] life_row(logic [W-1:0] u, m, l,
                                            logic [2:0] ln, rn);
    logic [W+1:0] eu, em, el;
    logic [W-1:0] r;
    eu = {rn[2], u, ln[2]};
    em = {rn[1], m, ln[1]};
    el = {rn[0], l, ln[0]};
    for (int i = 0; i < W; i++) begin
      int cnt;
      cnt = int'(eu[i]) + int'(eu[i+1]) + int'(eu[i+2]) + int'(em[i]) +
            int'(em[i+2]) + int'(el[i]) + int'(el[i+1]) + int'(el[i+2]);
      r[i] = (cnt == 3) || (em[i+1] && cnt == 2);
    end
    return r;
  endfunction

  task automatic load(int r, logic [W-1:0] d);
    @(negedge clk);
    ld = 1'b1; ld_row = RW'(r); ld_data = d;
    @(negedge clk);
    ld = 1'b0;
    g[r] = d;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // inject: pulse ld (R8) and sync (R9) while busy
  task automatic run_row(int r, logic [2:0] ln, logic [2:0] rn, bit inject,
                         string tag);
    logic [W-1:0] u, m, l, nw;
    item_t it;
    int cnt;
    u  = (r == 0) ? '0 : last_mid;
    m  = g[r];
    l  = (r == ROWS-1) ? '0 : g[r+1];
    nw = life_row(u, m, l, ln, rn);
    @(negedge clk);
    nbr_l = ln; nbr_r = rn; row = RW'(r); sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      if (inject && cnt == 3) begin
        ld = 1'b1; ld_row = RW'(9); ld_data = 8'hFF;
        sync = 1'b1; row = RW'(5);
      end else begin
        ld = 1'b0; sync = 1'b0;
      end
      @(negedge clk);
      if (cnt > 100) break;
    end
    ld = 1'b0; sync = 1'b0;
    check($sformatf("R7 busy length row %0d", r), cnt, W + 5);
    it.row = RW'(r); it.word = nw;
    it.el = {u[0], m[0], l[0]}; it.er = {u[W-1], m[W-1], l[W-1]};
    it.chk_e = 1; it.tag = tag;
    exp_q.push_back(it);
    g[r] = nw;
    last_mid = m;
    drain();
  endtask

  task automatic peek(int r, string tag);
    item_t it;
    it.row = RW'(r); it.word = g[r]; it.el = '0; it.er = '0;
    it.chk_e = 0; it.tag = tag;
    exp_q.push_back(it);
    drain();
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q[0];
        disp_row = it.row;
        @(negedge clk);
        check($sformatf("%s word row %0d", it.tag, it.row), disp_data, it.word);
        if (it.chk_e) begin
          check($sformatf("R6 edge_l row %0d", it.row), edge_l, it.el);
          check($sformatf("R6 edge_r row %0d", it.row), edge_r, it.er);
        end
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat [10];
    pat = '{8'h00, 8'h1C, 8'h00, 8'h24, 8'h3C, 8'h5A, 8'hE7, 8'h18, 8'h99, 8'h3C};
    for (int i = 0; i < ROWS; i++) g[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 edge_l", edge_l, 0);
    check("R1 edge_r", edge_r, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) load(i, pat[i]);
    load(477, 8'hA5); load(478, 8'h7E); load(479, 8'hDB);
    for (int i = 10; i < 12; i++) load(i, '0);
    // R8/R10 seeded rows read back through the display port
    peek(3, "R8/R10 load");
    peek(479, "R8/R10 load");
    // frame 1: dead neighbours, rule and previous-row buffer
    for (int r = 0; r < 9; r++)
      run_row(r, 3'b000, 3'b000, r == 4, "R2/R3");
    // R8 load during busy ignored, row 9 keeps its seed
    peek(9, "R8 ignored");
    // frame 2: live neighbour edges
    for (int r = 0; r < 9; r++)
      run_row(r, 3'(r) ^ 3'b101, {r[0], r[1], r[0] ^ r[1]}, 0, "R2/R5");
    check("R8 row 9 after frame 2", g[9], 8'h3C);
    // bottom boundary
    run_row(478, 3'b010, 3'b111, 0, "R3/R5");
    run_row(479, 3'b111, 3'b101, 0, "R4");
    // R9 check: sync during busy did not start row 5 extra
    peek(5, "R9 no extra row");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule